// File: doc/BRIEF.md
# Pipeline Operand Bypass and Load Interlock Unit

This unit resolves read-after-write hazards for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). For each of the two source operands of the instruction now in execute, it checks whether a later stage still holds an unwritten result for that register. It then steers the ALU operand multiplexers to the newest copy. A dependent ALU instruction can therefore issue directly behind its producer, with no two-cycle wait.

The unit also covers two cases that bypassing alone does not fix. First, when the register file is read in decode during the same cycle that writeback writes the same register, it tells the read ports to pass the incoming write data through. Second, when a load sits in execute and the instruction in decode reads the loaded register, the data cannot arrive in time. The unit then freezes the program counter and the fetch/decode register for one cycle, and clears the control bits entering execute so that a bubble goes down the pipe.

The unit is purely combinational. Its inputs are register ids, write enables and the memory-read flag taken from the pipeline registers. Its outputs are multiplexer selects and the stall controls.

Top module: `hazard_resolver`

## Requirements
- R1: An execute-stage source is bypassed from the memory stage, with select code 2'b10, when the memory-stage write enable is 1, its destination is nonzero, and its destination equals the source id.
- R2: When R1 does not apply, an execute-stage source is bypassed from the writeback stage, with select code 2'b01, when the writeback write enable is 1, its destination is nonzero, and its destination equals the source id.
- R3: When both the memory stage and the writeback stage match a source, the select is 2'b10, because the memory stage holds the younger result.
- R4: A source id of 0, a cleared write enable, or a destination that differs from the source gives select 2'b00 (register file).
- R5: The selects for operand A and operand B are worked out independently of each other. Each follows only its own source id.
- R6: A write-through flag for a decode read port is 1 exactly when the writeback write enable is 1, the writeback destination is nonzero, and it equals that port's id.
- R7: The stall output is 1 exactly when the execute-stage memory-read flag is 1, the execute destination is nonzero, and it equals either decode source id.
- R8: An execute-stage producer whose memory-read flag is 0 never causes a stall, even when its destination matches a decode source.
- R9: The front-freeze output and the bubble output are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | REG_W | Source A id of the instruction in execute |
| ex_src_b | input | REG_W | Source B id of the instruction in execute |
| mem_dst | input | REG_W | Destination id held in the execute/memory register |
| mem_wen | input | 1 | Register write enable held in the execute/memory register |
| wb_dst | input | REG_W | Destination id held in the memory/writeback register |
| wb_wen | input | 1 | Register write enable held in the memory/writeback register |
| id_src_a | input | REG_W | Source A id read in decode |
| id_src_b | input | REG_W | Source B id read in decode |
| ex_dst | input | REG_W | Destination id held in the decode/execute register |
| ex_mrd | input | 1 | Memory-read flag held in the decode/execute register |
| fwd_a | output | 2 | Operand A select (00 register file, 10 memory stage, 01 writeback) |
| fwd_b | output | 2 | Operand B select, same coding as fwd_a |
| thru_a | output | 1 | Decode read port A takes the writeback data |
| thru_b | output | 1 | Decode read port B takes the writeback data |
| hold_front | output | 1 | Freeze the program counter and the fetch/decode register |
| bubble | output | 1 | Clear the control bits entering execute |

## Verification
The bound checker evaluates every input combination the pipeline presents. It confirms that any nonzero select or write-through flag is backed by an enabled, nonzero, matching producer, and that register 0 never selects a bypass. It also confirms that the memory stage wins over writeback, that a stall only comes from a load, and that freeze and bubble never disagree. The exhaustive sweeps over a two-bit register id space show what no single-cycle implication can. These are that every real match is taken rather than dropped, that the two operands do not interfere with each other, and that a matching ALU producer stays free of stalls.

// File: rtl/hzu_pkg.sv
package hzu_pkg;

    // Operand multiplexer codes; the datapath decodes these bit patterns.
    typedef enum logic [1:0] {
        OPND_REGFILE  = 2'b00,
        OPND_FROM_WB  = 2'b01,
        OPND_FROM_MEM = 2'b10
    } opnd_src_e;

    localparam int ID_CMP_W = 32;

    // A pending producer matches a reader when it writes, is not register 0,
    // and names the same register.
    function automatic logic pend_match(input logic [ID_CMP_W-1:0] src,
                                        input logic [ID_CMP_W-1:0] dst,
                                        input logic                wen);
        return wen && (dst != '0) && (dst == src);
    endfunction

endpackage

// File: rtl/hzu_bypass_sel.sv
module hzu_bypass_sel
    import hzu_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int NSRC  = 2
) (
    input  logic [NSRC-1:0][REG_W-1:0] src,
    input  logic [REG_W-1:0]           mem_dst,
    input  logic                       mem_wen,
    input  logic [REG_W-1:0]           wb_dst,
    input  logic                       wb_wen,
    output opnd_src_e                  sel [NSRC]
);

    for (genvar i = 0; i < NSRC; i++) begin : g_opnd
        logic hit_mem;
        logic hit_wb;
        assign hit_mem = pend_match(ID_CMP_W'(src[i]), ID_CMP_W'(mem_dst), mem_wen);
        assign hit_wb  = pend_match(ID_CMP_W'(src[i]), ID_CMP_W'(wb_dst), wb_wen);
        always_comb begin
            if (hit_mem)     sel[i] = OPND_FROM_MEM;
            else if (hit_wb) sel[i] = OPND_FROM_WB;
            else             sel[i] = OPND_REGFILE;
        end
    end

endmodule

// File: rtl/hzu_rf_through.sv
module hzu_rf_through
    import hzu_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int NRD   = 2
) (
    input  logic [NRD-1:0][REG_W-1:0] rd_id,
    input  logic [REG_W-1:0]          wr_id,
    input  logic                      wr_en,
    output logic [NRD-1:0]            thru
);

    for (genvar i = 0; i < NRD; i++) begin : g_port
        assign thru[i] = pend_match(ID_CMP_W'(rd_id[i]), ID_CMP_W'(wr_id), wr_en);
    end

endmodule

// File: rtl/hzu_load_interlock.sv
module hzu_load_interlock
    import hzu_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int NRD   = 2
) (
    input  logic [NRD-1:0][REG_W-1:0] dec_src,
    input  logic [REG_W-1:0]          ld_dst,
    input  logic                      ld_flag,
    output logic                      stall
);

    logic [NRD-1:0] hit;

    for (genvar i = 0; i < NRD; i++) begin : g_src
        assign hit[i] = pend_match(ID_CMP_W'(dec_src[i]), ID_CMP_W'(ld_dst), ld_flag);
    end

    assign stall = |hit;

endmodule

// File: rtl/hazard_resolver.sv
module hazard_resolver
    import hzu_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] ex_src_a,
    input  logic [REG_W-1:0] ex_src_b,
    input  logic [REG_W-1:0] mem_dst,
    input  logic             mem_wen,
    input  logic [REG_W-1:0] wb_dst,
    input  logic             wb_wen,
    input  logic [REG_W-1:0] id_src_a,
    input  logic [REG_W-1:0] id_src_b,
    input  logic [REG_W-1:0] ex_dst,
    input  logic             ex_mrd,
    output logic [1:0]       fwd_a,
    output logic [1:0]       fwd_b,
    output logic             thru_a,
    output logic             thru_b,
    output logic             hold_front,
    output logic             bubble
);

    localparam int NOPND = 2;

    logic [NOPND-1:0][REG_W-1:0] ex_srcs;
    logic [NOPND-1:0][REG_W-1:0] id_srcs;
    opnd_src_e                   sel [NOPND];
    logic [NOPND-1:0]            thru;
    logic                        ld_stall;

    assign ex_srcs = {ex_src_b, ex_src_a};
    assign id_srcs = {id_src_b, id_src_a};

    hzu_bypass_sel #(.REG_W(REG_W), .NSRC(NOPND)) u_byp (
        .src     (ex_srcs),
        .mem_dst (mem_dst),
        .mem_wen (mem_wen),
        .wb_dst  (wb_dst),
        .wb_wen  (wb_wen),
        .sel     (sel)
    );

    hzu_rf_through #(.REG_W(REG_W), .NRD(NOPND)) u_thru (
        .rd_id (id_srcs),
        .wr_id (wb_dst),
        .wr_en (wb_wen),
        .thru  (thru)
    );

    hzu_load_interlock #(.REG_W(REG_W), .NRD(NOPND)) u_ilk (
        .dec_src (id_srcs),
        .ld_dst  (ex_dst),
        .ld_flag (ex_mrd),
        .stall   (ld_stall)
    );

    assign fwd_a      = sel[0];
    assign fwd_b      = sel[1];
    assign thru_a     = thru[0];
    assign thru_b     = thru[1];
    assign hold_front = ld_stall;
    assign bubble     = ld_stall;

endmodule

// File: rtl/hazard_resolver_chk.sv
module hazard_resolver_chk #(
    parameter int REG_W = 5
) (
    input logic [REG_W-1:0] ex_src_a,
    input logic [REG_W-1:0] ex_src_b,
    input logic [REG_W-1:0] mem_dst,
    input logic             mem_wen,
    input logic [REG_W-1:0] wb_dst,
    input logic             wb_wen,
    input logic [REG_W-1:0] id_src_a,
    input logic [REG_W-1:0] id_src_b,
    input logic [REG_W-1:0] ex_dst,
    input logic             ex_mrd,
    input logic [1:0]       fwd_a,
    input logic [1:0]       fwd_b,
    input logic             thru_a,
    input logic             thru_b,
    input logic             hold_front,
    input logic             bubble
);

    always_comb begin
        // R1
        fwd_a_mem_chk: assert (fwd_a != 2'b10 || (mem_wen && mem_dst != '0 && mem_dst == ex_src_a))
            else $error("fwd_a memory select without a matching producer");
        // R2
        fwd_b_wb_chk: assert (fwd_b != 2'b01 || (wb_wen && wb_dst != '0 && wb_dst == ex_src_b))
            else $error("fwd_b writeback select without a matching producer");
        // R3
        mem_prio_chk: assert (!(mem_wen && mem_dst != '0 && mem_dst == ex_src_a) || fwd_a == 2'b10)
            else $error("memory stage not preferred on operand A");
        // R4
        zero_src_chk: assert ((ex_src_a != '0 || fwd_a == 2'b00) && (ex_src_b != '0 || fwd_b == 2'b00)
                              && fwd_a != 2'b11 && fwd_b != 2'b11)
            else $error("register 0 or illegal code forwarded");
        // R6
        thru_src_chk: assert ((!thru_a && !thru_b) || (wb_wen && wb_dst != '0))
            else $error("write-through without an active write");
        // R8
        stall_load_chk: assert (!hold_front || (ex_mrd && ex_dst != '0))
            else $error("stall raised without a load in execute");
        // R9
        hold_bubble_chk: assert (hold_front == bubble)
            else $error("freeze and bubble disagree");
    end

endmodule

bind hazard_resolver hazard_resolver_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/sim_hazard_resolver.sv
module sim_hazard_resolver;

    localparam int RW = 2;
    localparam int NR = 1 << RW;

    logic clk = 1'b0;
    always #4ns clk = ~clk;

    logic [RW-1:0] ex_src_a, ex_src_b, mem_dst, wb_dst, id_src_a, id_src_b, ex_dst;
    logic          mem_wen, wb_wen, ex_mrd;
    logic [1:0]    fwd_a, fwd_b;
    logic          thru_a, thru_b, hold_front, bubble;

    int n_chk  = 0;
    int n_fail = 0;

    hazard_resolver #(.REG_W(RW)) u0 (
        .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
        .mem_dst(mem_dst), .mem_wen(mem_wen),
        .wb_dst(wb_dst), .wb_wen(wb_wen),
        .id_src_a(id_src_a), .id_src_b(id_src_b),
        .ex_dst(ex_dst), .ex_mrd(ex_mrd),
        .fwd_a(fwd_a), .fwd_b(fwd_b),
        .thru_a(thru_a), .thru_b(thru_b),
        .hold_front(hold_front), .bubble(bubble)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_sel(int src, int md, int mw, int wd, int ww);
        if (src != 0 && mw != 0 && md == src) return 2;
        if (src != 0 && ww != 0 && wd == src) return 1;
        return 0;
    endfunction

    function automatic string sel_tag(int src, int md, int mw, int wd, int ww);
        bit m = (src != 0 && mw != 0 && md == src);
        bit w = (src != 0 && ww != 0 && wd == src);
        if (m && w) return "R3";
        if (m) return "R1";
        if (w) return "R2";
        return "R4";
    endfunction

    task automatic settle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_inputs();
        ex_src_a = '0; ex_src_b = '0; mem_dst = '0; mem_wen = 1'b0;
        wb_dst = '0; wb_wen = 1'b0; id_src_a = '0; id_src_b = '0;
        ex_dst = '0; ex_mrd = 1'b0;
    endtask

    initial begin
        clear_inputs();
        settle();
        // idle state: nothing pending
        check("R4", int'(fwd_a), 0);
        check("R4", int'(fwd_b), 0);
        check("R7", int'(hold_front), 0);

        // operand A sweep, operand B held on register 0
        for (int s = 0; s < NR; s++)
            for (int md = 0; md < NR; md++)
                for (int mw = 0; mw < 2; mw++)
                    for (int wd = 0; wd < NR; wd++)
                        for (int ww = 0; ww < 2; ww++) begin
                            ex_src_a = RW'(s); mem_dst = RW'(md); mem_wen = mw[0];
                            wb_dst = RW'(wd); wb_wen = ww[0];
                            settle();
                            check(sel_tag(s, md, mw, wd, ww), int'(fwd_a), exp_sel(s, md, mw, wd, ww));
                            check("R4", int'(fwd_b), 0);
                        end

        // both operands swept against one fixed producer pair (R5)
        mem_dst = RW'(1); mem_wen = 1'b1; wb_dst = RW'(2); wb_wen = 1'b1;
        for (int a = 0; a < NR; a++)
            for (int b = 0; b < NR; b++) begin
                ex_src_a = RW'(a); ex_src_b = RW'(b);
                settle();
                check("R5", int'(fwd_a), exp_sel(a, 1, 1, 2, 1));
                check("R5", int'(fwd_b), exp_sel(b, 1, 1, 2, 1));
            end

        // write-through sweep on both decode ports (R6)
        clear_inputs();
        for (int wd = 0; wd < NR; wd++)
            for (int ww = 0; ww < 2; ww++)
                for (int a = 0; a < NR; a++)
                    for (int b = 0; b < NR; b++) begin
                        wb_dst = RW'(wd); wb_wen = ww[0];
                        id_src_a = RW'(a); id_src_b = RW'(b);
                        settle();
                        check("R6", int'(thru_a), int'(ww != 0 && wd != 0 && wd == a));
                        check("R6", int'(thru_b), int'(ww != 0 && wd != 0 && wd == b));
                    end

        // load-use interlock sweep (R7, R8, R9)
        clear_inputs();
        for (int ed = 0; ed < NR; ed++)
            for (int mr = 0; mr < 2; mr++)
                for (int a = 0; a < NR; a++)
                    for (int b = 0; b < NR; b++) begin
                        ex_dst = RW'(ed); ex_mrd = mr[0];
                        id_src_a = RW'(a); id_src_b = RW'(b);
                        settle();
                        if (mr == 0)
                            check("R8", int'(hold_front), 0);
                        else
                            check("R7", int'(hold_front),
                                  int'(ed != 0 && (ed == a || ed == b)));
                        check("R9", int'(bubble), int'(hold_front));
                    end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule